// File: doc/BRIEF.md
# SPI Command Bridge to a Byte-Wide NAND Bus

This block is an SPI slave (clock idle low, data sampled on the rising SCLK edge, changed on the falling edge) that turns command frames from a host into activity on an 8-bit raw NAND flash bus and on a handful of board output pins. Every chip-select frame opens with one opcode byte. The opcode picks the meaning of the bytes that follow. They can be NAND data to strobe out with WE#, a new value for the 8-bit pin configuration register, or idle bytes during which the block fetches NAND data with RE# and returns it on MISO. Two further opcodes switch a fifth LED that lives outside the configuration register.

The configuration register drives four LEDs, a fan enable, and the NAND address-latch, command-latch and active-low chip-enable lines. All of these pins are outputs only. The SPI pins are oversampled by the system clock, so the whole block runs in one clock domain. The host keeps each SCLK half period at least `STROBE_CYC + 4` system clock cycles long. This gives a NAND read strobe time to finish between the last rising edge of one byte and the falling edge where the next byte's first bit must appear.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the configuration register holds 0x80, so chip-enable is high and LEDs, fan, ALE and CLE are low. LED5 is off, WE# and RE# are high, the data bus is not driven and MISO is 0.
- R2: Opcode 0x09 loads the byte that follows it into the configuration register. In that register, bits 3..0 drive LED4..LED1, bit 4 drives the fan, bit 5 drives ALE, bit 6 drives CLE and bit 7 drives chip-enable (active low). Any later bytes in the same frame are ignored.
- R3: Opcode 0x0C switches LED5 on and opcode 0x0D switches it off. Neither takes a payload, and neither changes the configuration register. Bytes after either opcode in the same frame are ignored.
- R4: Opcode 0x08 starts a NAND write. Each data byte is put on the bus with one WE# pulse when the byte after it has been received. A frame of n data bytes followed by one idle byte therefore gives exactly n writes, in order, and the idle byte is never written.
- R5: A WE# pulse is low for exactly STROBE_CYC clock cycles. The data bus is driven for the whole pulse and is held, unchanged, for the cycle in which WE# rises.
- R6: Opcode 0x0A is a normal read. MISO is 0 during the opcode and one idle byte. After that, each byte slot carries the next NAND byte, most significant bit first.
- R7: Opcode 0x0B is a fast read. It behaves like R6, but the idle stretch is four bytes long.
- R8: An RE# pulse is low for exactly STROBE_CYC cycles and never overlaps WE# or a driven data bus. One pulse is issued when each byte just before a data slot completes, so a read frame with n data bytes produces n+1 pulses.
- R9: After an opcode other than 0x08 to 0x0D, the rest of the frame causes no strobes and no change to the configuration register or LED5, and MISO stays 0.
- R10: When chip-select is released in the middle of a command, the decoder returns to waiting for an opcode and any write byte still held back is discarded. A strobe already started runs to its full width.
- R11: While chip-select is high, MISO is 0 and neither the configuration pins nor LED5 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip-select, active low; frames a command |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| nand_dq_in | input | 8 | Data bus value read from the NAND device |
| nand_dq_out | output | 8 | Data bus value driven toward the NAND device |
| nand_dq_oe | output | 1 | High while the bridge drives the data bus |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_ale | output | 1 | NAND address latch enable (config bit 5) |
| nand_cle | output | 1 | NAND command latch enable (config bit 6) |
| nand_ce_n | output | 1 | NAND chip enable, active low (config bit 7) |
| led | output | 4 | LED1..LED4 (config bits 0..3) |
| fan | output | 1 | Fan enable (config bit 4) |
| led5 | output | 1 | Fifth LED, driven by its own opcodes |

## Verification
The tightest overlap is a chip-select release that arrives while a WE# pulse is being issued for the byte that the final received byte has just flushed out. The bench provokes it by raising chip-select two system clocks after the last rising SCLK edge of a write frame. That places the abort in the same few cycles as the strobe start. The outcome is judged on three points: exactly one write with the right data, a WE# pulse of full width, and the next frame being decoded from its opcode again.

// File: rtl/snb_pkg.sv
package snb_pkg;

    localparam int BYTE_W = 8;

    // Command opcodes (first byte of every frame)
    localparam logic [BYTE_W-1:0] OP_NAND_WR  = 8'h08;
    localparam logic [BYTE_W-1:0] OP_CFG_WR   = 8'h09;
    localparam logic [BYTE_W-1:0] OP_RD_NORM  = 8'h0A;
    localparam logic [BYTE_W-1:0] OP_RD_FAST  = 8'h0B;
    localparam logic [BYTE_W-1:0] OP_LED5_ON  = 8'h0C;
    localparam logic [BYTE_W-1:0] OP_LED5_OFF = 8'h0D;

    // Idle bytes between a read opcode and the first data slot
    localparam int LEAD_NORM = 1;
    localparam int LEAD_FAST = 4;
    localparam int LEAD_W    = $clog2(LEAD_FAST + 1);

    // Pin configuration register; field order fixes the bit positions
    typedef struct packed {
        logic       ce_n;
        logic       cle;
        logic       ale;
        logic       fan;
        logic [3:0] led;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{ce_n: 1'b1, cle: 1'b0, ale: 1'b0,
                                       fan: 1'b0, led: 4'h0};

    typedef enum logic [2:0] {
        DS_OPCODE,
        DS_CFG,
        DS_WRITE,
        DS_RD_LEAD,
        DS_RD_DATA,
        DS_SINK
    } dec_state_e;

    typedef enum logic [1:0] {
        SS_IDLE,
        SS_WR,
        SS_WR_HOLD,
        SS_RD
    } strb_state_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] data;
    } nand_req_t;

    function automatic logic [LEAD_W-1:0] lead_count(input logic fast);
        return fast ? LEAD_W'(LEAD_FAST) : LEAD_W'(LEAD_NORM);
    endfunction

endpackage

// File: rtl/snb_spi_front.sv
module snb_spi_front
    import snb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              frame_act,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [SYNC_STAGES-1:0] sclk_sync;
    logic [SYNC_STAGES-1:0] cs_sync;
    logic [SYNC_STAGES-1:0] mosi_sync;
    logic                   sclk_prev;
    logic                   sclk_s;
    logic                   mosi_s;
    logic                   rise;
    logic                   fall;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_W-2:0]      rx_sh;
    logic [BYTE_W-1:0]      tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sync <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
            cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
            mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
            sclk_prev <= sclk_s;
        end
    end

    assign sclk_s    = sclk_sync[SYNC_STAGES-1];
    assign mosi_s    = mosi_sync[SYNC_STAGES-1];
    assign frame_act = ~cs_sync[SYNC_STAGES-1];
    assign rise      = sclk_s & ~sclk_prev;
    assign fall      = ~sclk_s & sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!frame_act) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else begin
                if (rise) begin
                    rx_sh   <= {rx_sh[BYTE_W-3:0], mosi_s};
                    bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sh, mosi_s};
                    end
                end
                if (fall) begin
                    if (bit_cnt == '0) begin
                        tx_sh <= tx_byte;
                    end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso = tx_sh[BYTE_W-1];

endmodule

// File: rtl/snb_cmd_decode.sv
module snb_cmd_decode
    import snb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] rd_data,
    output pin_cfg_t          cfg,
    output logic              led5,
    output nand_req_t         req,
    output logic [BYTE_W-1:0] tx_byte
);

    dec_state_e        state;
    logic [LEAD_W-1:0] lead_left;
    logic [BYTE_W-1:0] pend_byte;
    logic              pend_vld;
    pin_cfg_t          cfg_q;
    logic              led5_q;
    nand_req_t         req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= DS_OPCODE;
            lead_left <= '0;
            pend_byte <= '0;
            pend_vld  <= 1'b0;
            cfg_q     <= CFG_RESET;
            led5_q    <= 1'b0;
            req_q     <= '0;
        end else begin
            req_q <= '0;
            if (byte_done) begin
                case (state)
                    DS_OPCODE: begin
                        case (rx_byte)
                            OP_NAND_WR: begin
                                state    <= DS_WRITE;
                                pend_vld <= 1'b0;
                            end
                            OP_CFG_WR:  state <= DS_CFG;
                            OP_RD_NORM: begin
                                state     <= DS_RD_LEAD;
                                lead_left <= lead_count(1'b0);
                            end
                            OP_RD_FAST: begin
                                state     <= DS_RD_LEAD;
                                lead_left <= lead_count(1'b1);
                            end
                            OP_LED5_ON: begin
                                led5_q <= 1'b1;
                                state  <= DS_SINK;
                            end
                            OP_LED5_OFF: begin
                                led5_q <= 1'b0;
                                state  <= DS_SINK;
                            end
                            default:    state <= DS_SINK;
                        endcase
                    end
                    DS_CFG: begin
                        cfg_q <= pin_cfg_t'(rx_byte);
                        state <= DS_SINK;
                    end
                    DS_WRITE: begin
                        if (pend_vld) begin
                            req_q.wr   <= 1'b1;
                            req_q.data <= pend_byte;
                        end
                        pend_byte <= rx_byte;
                        pend_vld  <= 1'b1;
                    end
                    DS_RD_LEAD: begin
                        if (lead_left == LEAD_W'(1)) begin
                            req_q.rd <= 1'b1;
                            state    <= DS_RD_DATA;
                        end else begin
                            lead_left <= lead_left - 1'b1;
                        end
                    end
                    DS_RD_DATA: req_q.rd <= 1'b1;
                    default: ;
                endcase
            end
            if (!frame_act) begin
                state    <= DS_OPCODE;
                pend_vld <= 1'b0;
            end
        end
    end

    assign cfg     = cfg_q;
    assign led5    = led5_q;
    assign req     = req_q;
    assign tx_byte = (state == DS_RD_DATA) ? rd_data : '0;

endmodule

// File: rtl/snb_nand_strobe.sv
module snb_nand_strobe
    import snb_pkg::*;
#(
    parameter int STROBE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  nand_req_t         req,
    input  logic [BYTE_W-1:0] dq_in,
    output logic              we_n,
    output logic              re_n,
    output logic              dq_oe,
    output logic [BYTE_W-1:0] dq_out,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

    strb_state_e      state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SS_IDLE;
            cnt     <= '0;
            dq_out  <= '0;
            rd_data <= '0;
        end else begin
            case (state)
                SS_IDLE: begin
                    if (req.wr) begin
                        dq_out <= req.data;
                        cnt    <= CNT_LOAD;
                        state  <= SS_WR;
                    end else if (req.rd) begin
                        cnt   <= CNT_LOAD;
                        state <= SS_RD;
                    end
                end
                SS_WR: begin
                    if (cnt == '0) state <= SS_WR_HOLD;
                    else           cnt   <= cnt - 1'b1;
                end
                SS_WR_HOLD: state <= SS_IDLE;
                SS_RD: begin
                    if (cnt == '0) begin
                        rd_data <= dq_in;
                        state   <= SS_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= SS_IDLE;
            endcase
        end
    end

    assign we_n  = (state != SS_WR);
    assign re_n  = (state != SS_RD);
    assign dq_oe = (state == SS_WR) || (state == SS_WR_HOLD);

endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
    import snb_pkg::*;
#(
    parameter int STROBE_CYC  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [7:0] nand_dq_in,
    output logic [7:0] nand_dq_out,
    output logic       nand_dq_oe,
    output logic       nand_we_n,
    output logic       nand_re_n,
    output logic       nand_ale,
    output logic       nand_cle,
    output logic       nand_ce_n,
    output logic [3:0] led,
    output logic       fan,
    output logic       led5
);

    logic              frame_act;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rd_data;
    pin_cfg_t          cfg;
    nand_req_t         req;

    snb_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .tx_byte   (tx_byte),
        .frame_act (frame_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    snb_cmd_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .frame_act (frame_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .rd_data   (rd_data),
        .cfg       (cfg),
        .led5      (led5),
        .req       (req),
        .tx_byte   (tx_byte)
    );

    snb_nand_strobe #(.STROBE_CYC(STROBE_CYC)) u_strobe (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .dq_in   (nand_dq_in),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_oe   (nand_dq_oe),
        .dq_out  (nand_dq_out),
        .rd_data (rd_data)
    );

    assign led       = cfg.led;
    assign fan       = cfg.fan;
    assign nand_ale  = cfg.ale;
    assign nand_cle  = cfg.cle;
    assign nand_ce_n = cfg.ce_n;

endmodule

// File: rtl/snb_checker.sv
module snb_checker #(
    parameter int STROBE_CYC = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe,
    input logic [7:0] nand_dq_out,
    input logic       nand_ale,
    input logic       nand_cle,
    input logic       nand_ce_n,
    input logic [3:0] led,
    input logic       fan,
    input logic       led5
);

    int we_low;
    int re_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low <= 0;
            re_low <= 0;
        end else begin
            we_low <= nand_we_n ? 0 : we_low + 1;
            re_low <= nand_re_n ? 0 : re_low + 1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (nand_ce_n && !nand_cle && !nand_ale && !fan && led == 4'h0
                        && !led5 && nand_we_n && nand_re_n && !nand_dq_oe && !spi_miso)); // R1

    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |-> nand_dq_oe); // R5

    AST_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (nand_dq_oe && $stable(nand_dq_out))); // R5

    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (we_low == STROBE_CYC)); // R5

    AST_RE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_re_n) |-> (re_low == STROBE_CYC)); // R8

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n)); // R8

    AST_RD_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe); // R8

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4)) |-> !spi_miso); // R11

    AST_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4))
        |-> $stable({nand_ce_n, nand_cle, nand_ale, fan, led, led5})); // R11

endmodule

bind spi_nand_bridge snb_checker #(.STROBE_CYC(STROBE_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_oe  (nand_dq_oe),
    .nand_dq_out (nand_dq_out),
    .nand_ale    (nand_ale),
    .nand_cle    (nand_cle),
    .nand_ce_n   (nand_ce_n),
    .led         (led),
    .fan         (fan),
    .led5        (led5)
);

// File: tb/spi_nand_bridge_bench.sv
module spi_nand_bridge_bench;

    localparam int STROBE_CYC = 2;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] nand_dq_in = 8'h00;
    logic [7:0] nand_dq_out;
    logic       nand_dq_oe, nand_we_n, nand_re_n;
    logic       nand_ale, nand_cle, nand_ce_n, fan, led5;
    logic [3:0] led;

    always #10 clk = ~clk;

    spi_nand_bridge #(.STROBE_CYC(STROBE_CYC)) u_spi_nand_bridge (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .nand_dq_in(nand_dq_in),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_ale(nand_ale), .nand_cle(nand_cle),
        .nand_ce_n(nand_ce_n), .led(led), .fan(fan), .led5(led5)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [7:0] exp_cfg  = 8'h80;
    logic       exp_led5 = 1'b0;
    logic [7:0] exp_wr[$];
    logic [7:0] rd_src[$];
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    int wr_seen = 0;
    int rd_seen = 0;
    int quiet   = 0;
    int we_cnt  = 0;
    int re_cnt  = 0;
    logic we_prev = 1'b1;
    logic re_prev = 1'b1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pins();
        return {nand_ce_n, nand_cle, nand_ale, fan, led};
    endfunction

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (spi_cs_n) quiet++;
            else          quiet = 0;
            if (quiet > 6) begin
                chk(pins() == exp_cfg, "R11 config pins idle", pins(), exp_cfg);
                chk(led5 == exp_led5, "R11 led5 idle", led5, exp_led5);
                chk(spi_miso == 1'b0, "R11 miso idle", spi_miso, 0);
            end
            // NAND write monitor
            if (!nand_we_n) begin
                we_cnt++;
                chk(nand_dq_oe, "R5 bus driven during WE#", nand_dq_oe, 1);
            end else if (!we_prev) begin
                chk(we_cnt == STROBE_CYC, "R5 WE# width", we_cnt, STROBE_CYC);
                chk(nand_dq_oe, "R5 bus held after WE#", nand_dq_oe, 1);
                if (exp_wr.size() == 0) begin
                    chk(1'b0, "R4 unexpected write", nand_dq_out, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_wr.pop_front();
                    chk(nand_dq_out == e, "R4 write data", nand_dq_out, e);
                end
                wr_seen++;
                we_cnt = 0;
            end
            // NAND read device model
            if (!nand_re_n) begin
                if (re_prev) nand_dq_in <= (rd_src.size() > 0) ? rd_src.pop_front() : 8'hEE;
                re_cnt++;
                chk(!nand_dq_oe, "R8 bus free during RE#", nand_dq_oe, 0);
                chk(nand_we_n, "R8 RE# and WE# exclusive", nand_we_n, 1);
            end else if (!re_prev) begin
                chk(re_cnt == STROBE_CYC, "R8 RE# width", re_cnt, STROBE_CYC);
                rd_seen++;
                re_cnt = 0;
            end
            we_prev = nand_we_n;
            re_prev = nand_re_n;
        end
    end

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit abort);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            if (abort && i == 0) begin
                repeat (2) @(negedge clk);
                spi_cs_n = 1'b1;
                repeat (HALF - 2) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            spi_sclk = 1'b0;
        end
    endtask

    task automatic run_frame(input bit abort_last);
        logic [7:0] r;
        rx_q.delete();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < tx_q.size(); k++) begin
            xfer(tx_q[k], r, abort_last && (k == tx_q.size() - 1));
            rx_q.push_back(r);
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (6 * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(pins() == 8'h80, "R1 config reset", pins(), 8'h80);
        chk(!led5, "R1 led5 off", led5, 0);
        chk(nand_we_n && nand_re_n && !nand_dq_oe, "R1 strobes idle",
            {nand_we_n, nand_re_n, nand_dq_oe}, 3'b110);
        chk(!spi_miso, "R1 miso low", spi_miso, 0);
        repeat (10) @(negedge clk);

        // R2 configuration write, trailing byte ignored
        exp_cfg = 8'h6A;
        tx_q = '{8'h09, 8'h6A, 8'h00};
        run_frame(1'b0);
        chk(led == 4'hA, "R2 LED field", led, 4'hA);
        chk(!fan, "R2 fan bit4", fan, 0);
        chk(nand_ale && nand_cle && !nand_ce_n, "R2 ALE/CLE/CE# bits 5..7",
            {nand_ce_n, nand_cle, nand_ale}, 3'b011);
        chk(pins() == 8'h6A, "R2 extra byte ignored", pins(), 8'h6A);

        exp_cfg = 8'h95;
        tx_q = '{8'h09, 8'h95};
        run_frame(1'b0);
        chk(pins() == 8'h95, "R2 second config", pins(), 8'h95);

        // R3 LED5 commands
        exp_led5 = 1'b1;
        tx_q = '{8'h0C};
        run_frame(1'b0);
        chk(led5, "R3 led5 on", led5, 1);
        chk(pins() == 8'h95, "R3 config untouched", pins(), 8'h95);
        exp_led5 = 1'b0;
        tx_q = '{8'h0D, 8'h0C};
        run_frame(1'b0);
        chk(!led5, "R3 led5 off, payload ignored", led5, 0);

        // R4 NAND write with trailing idle byte
        wr_seen = 0;
        exp_wr = '{8'h11, 8'h22, 8'h33};
        tx_q = '{8'h08, 8'h11, 8'h22, 8'h33, 8'h00};
        run_frame(1'b0);
        chk(wr_seen == 3, "R4 write count", wr_seen, 3);
        chk(exp_wr.size() == 0, "R4 all writes seen", exp_wr.size(), 0);

        // R6 normal read
        rd_seen = 0;
        rd_src = '{8'hC3, 8'h5A, 8'h7E, 8'h99};
        tx_q = '{8'h0A, 8'h00, 8'h00, 8'h00, 8'h00};
        run_frame(1'b0);
        chk(rx_q[0] == 8'h00 && rx_q[1] == 8'h00, "R6 zero lead", {rx_q[0], rx_q[1]}, 0);
        chk(rx_q[2] == 8'hC3, "R6 data0", rx_q[2], 8'hC3);
        chk(rx_q[3] == 8'h5A, "R6 data1", rx_q[3], 8'h5A);
        chk(rx_q[4] == 8'h7E, "R6 data2", rx_q[4], 8'h7E);
        chk(rd_seen == 4, "R8 read strobes incl. prefetch", rd_seen, 4);
        rd_src.delete();

        // R7 fast read
        rd_seen = 0;
        rd_src = '{8'h81, 8'h42, 8'h24};
        tx_q = '{8'h0B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        run_frame(1'b0);
        for (int k = 0; k < 5; k++)
            chk(rx_q[k] == 8'h00, "R7 zero lead", rx_q[k], 0);
        chk(rx_q[5] == 8'h81, "R7 data0", rx_q[5], 8'h81);
        chk(rx_q[6] == 8'h42, "R7 data1", rx_q[6], 8'h42);
        chk(rd_seen == 3, "R7 read strobe count", rd_seen, 3);
        rd_src.delete();

        // R9 unknown opcode
        rd_seen = 0;
        wr_seen = 0;
        tx_q = '{8'h5A, 8'h09, 8'h0C, 8'h08, 8'h55};
        run_frame(1'b0);
        chk(rd_seen == 0 && wr_seen == 0, "R9 no strobes", rd_seen + wr_seen, 0);
        for (int k = 0; k < 5; k++)
            chk(rx_q[k] == 8'h00, "R9 miso zero", rx_q[k], 0);
        chk(pins() == 8'h95 && !led5, "R9 state unchanged", {led5, pins()}, 9'h095);

        // R10 abort while a write strobe is starting
        wr_seen = 0;
        exp_wr = '{8'hA5};
        tx_q = '{8'h08, 8'hA5, 8'h3C};
        run_frame(1'b1);
        chk(wr_seen == 1, "R10 one write, held byte dropped", wr_seen, 1);
        chk(exp_wr.size() == 0, "R10 flushed write seen", exp_wr.size(), 0);
        exp_cfg = 8'h80;
        tx_q = '{8'h09, 8'h80};
        run_frame(1'b0);
        chk(pins() == 8'h80, "R10 next frame decoded as opcode", pins(), 8'h80);
        chk(wr_seen == 1, "R10 no write after abort", wr_seen, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule